// File: doc/BRIEF.md
# Flash command pipeline controller

This block sequences program and erase requests for a non-volatile memory command engine. Software loads a one-deep command buffer in three bus steps: an aligned data word written to the memory address space, then a command code, then a launch, which is a write of 1 to the buffer-empty bit of the status word. As soon as the single execution slot is free, the buffered request moves into it. A second request can therefore be loaded while the first one runs.

The block keeps sticky protection-violation and access-error flags, a fail bit that only special test mode can write, and two derived flags: buffer-empty and all-complete. Each derived flag drives an interrupt request through its own enable bit. The execution back end is modelled as a busy slot that runs for a latency taken from an input. It can report a fault, which flushes both slots.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, flag_empty and flag_done read 1, and flag_prot, flag_acc, flag_fail, irq_empty, irq_done and exec_busy read 0.
- R2: A status write clears flag_prot when bit 1 is 1 and clears flag_acc when bit 2 is 1. A 0 in either bit leaves that flag unchanged.
- R3: A sequence of an aligned word write (arr_addr[0]=0), a legal code, and a status write with bit 0 = 1 places the request in the buffer, so flag_empty reads 0 in the next cycle. One cycle after that, exec_start pulses with the buffered code, address and data, and flag_empty returns to 1.
- R4: A status write with bit 0 = 0 after the word step and before the launch aborts the sequence and sets flag_acc. The same write outside a sequence sets nothing and launches nothing.
- R5: flag_done is 0 whenever flag_empty is 0 or a command executes. When a finishing command is directly replaced by the buffered one, flag_done stays 0. It rises only when both slots are empty.
- R6: While flag_prot or flag_acc is set, every sequence step is ignored and a buffered request is held and does not start. It starts once the flags are cleared.
- R7: flag_acc is set by any step out of order: a code with no word pending, a second word, a launch before the code, a word with arr_addr[0]=1, or a word while the buffer is occupied.
- R8: Legal codes are 0x11 verify, 0x22 program, 0x33 sector erase, 0x44 mass erase and 0x55 erase abort. Any other code sets flag_acc. Code 0x55 also sets flag_acc and ends an executing sector erase at once.
- R9: A word flagged by prot_hit, followed by code 0x22, 0x33 or 0x44, sets flag_prot and cancels the sequence. The verify code 0x11 ignores prot_hit.
- R10: exec_fault while a command executes sets flag_acc, ends the active command and discards the buffered one unstarted.
- R11: stop_req sets flag_acc while flag_done is 0 and has no effect while flag_done is 1.
- R12: Bit 3 of a status write loads flag_fail only while special_mode is 1. While flag_fail is 1, word writes are ignored and start no sequence.
- R13: irq_empty equals flag_empty AND enable bit 0, and irq_done equals flag_done AND enable bit 1. Both enable bits are loaded by ie_wr and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Test mode; makes the fail bit writable |
| arr_wr | input | 1 | Word write into the memory address space |
| arr_addr | input | ADDR_W | Byte address of the word write |
| arr_data | input | DATA_W | Data of the word write |
| prot_hit | input | 1 | Address of the word write lies in a protected region |
| cmd_wr | input | 1 | Command code write |
| cmd_code | input | 8 | Command code |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 4 | Status write data: bit0 empty/launch, bit1 prot, bit2 acc, bit3 fail |
| ie_wr | input | 1 | Interrupt-enable write strobe |
| ie_wdata | input | 2 | bit0 empty enable, bit1 complete enable |
| stop_req | input | 1 | Stop request from the system |
| exec_lat | input | CNT_W | Extra execution cycles for the command entering the slot |
| exec_fault | input | 1 | Fault reported by the back end |
| flag_empty | output | 1 | Buffer-empty flag |
| flag_done | output | 1 | All-complete flag |
| flag_prot | output | 1 | Protection-violation flag |
| flag_acc | output | 1 | Access-error flag |
| flag_fail | output | 1 | Fail bit |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Completion interrupt request |
| exec_start | output | 1 | One-cycle pulse as a command enters execution |
| exec_busy | output | 1 | A command occupies the execution slot |
| exec_cmd | output | 8 | Code of the executing command |
| exec_addr | output | ADDR_W | Address of the executing command |
| exec_data | output | DATA_W | Data of the executing command |

## Verification
The hardest states to reach from the ports are those in which a request sits in the buffer behind a running command while an error, a stop, a fault or an erase abort arrives. Only this combination separates held requests from discarded ones and shows whether the completion flag stays low across the hand-off. The stimulus sets a long execution latency through exec_lat, so the first command is still running while a complete second sequence loads into the buffer. Faults, stops, abort codes and out-of-order words are then injected at known cycles.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

   localparam int CMD_W = 8;
   localparam int SW_W  = 4;

   // status write bit positions
   localparam int SB_EMPTY = 0;
   localparam int SB_PROT  = 1;
   localparam int SB_ACC   = 2;
   localparam int SB_FAIL  = 3;

   localparam logic [CMD_W-1:0] OP_VERIFY = 8'h11;
   localparam logic [CMD_W-1:0] OP_PROG   = 8'h22;
   localparam logic [CMD_W-1:0] OP_SERASE = 8'h33;
   localparam logic [CMD_W-1:0] OP_MERASE = 8'h44;
   localparam logic [CMD_W-1:0] OP_ABORT  = 8'h55;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WORD = 2'd1,
      SQ_CMD  = 2'd2
   } seq_st_e;

   function automatic logic op_legal(input logic [CMD_W-1:0] c);
      case (c)
         OP_VERIFY, OP_PROG, OP_SERASE, OP_MERASE, OP_ABORT: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic op_alters(input logic [CMD_W-1:0] c);
      case (c)
         OP_PROG, OP_SERASE, OP_MERASE: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/fcc_seq.sv
module fcc_seq
   import fcc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int WORD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              arr_wr,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              prot_hit,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_code,
   input  logic              stat_wr,
   input  logic [SW_W-1:0]   stat_wdata,
   input  logic              stop_req,
   input  logic              fault_evt,
   input  logic              done_flag,
   input  logic              buf_free,
   output logic              launch,
   output logic              kill_serase,
   output logic [CMD_W-1:0]  l_cmd,
   output logic [ADDR_W-1:0] l_addr,
   output logic [DATA_W-1:0] l_data,
   output logic              prot_q,
   output logic              acc_q,
   output logic              fail_q
);

   localparam int ALIGN_B = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

   seq_st_e     st, nxt;
   logic        misaligned;
   logic        seq_acc, seq_prot, take_word, take_cmd;
   logic        acc_set, prot_set, err_any;
   logic [CMD_W-1:0]  cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic        hit_q;

   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_wb
      $error("fcc_seq: WORD_BYTES must be a power of two");
   end
   if (ADDR_W <= ALIGN_B) begin : g_bad_aw
      $error("fcc_seq: ADDR_W too small for the word size");
   end

   if (WORD_BYTES > 1) begin : g_align
      assign misaligned = |arr_addr[ALIGN_B-1:0];
   end else begin : g_noalign
      assign misaligned = 1'b0;
   end

   assign err_any = prot_q | acc_q;

   always_comb begin
      nxt         = st;
      seq_acc     = 1'b0;
      seq_prot    = 1'b0;
      launch      = 1'b0;
      kill_serase = 1'b0;
      take_word   = 1'b0;
      take_cmd    = 1'b0;
      if (!err_any) begin
         case (st)
            SQ_IDLE: begin
               if (arr_wr && !fail_q) begin
                  if (misaligned || !buf_free) seq_acc = 1'b1;
                  else begin
                     take_word = 1'b1;
                     nxt       = SQ_WORD;
                  end
               end else if (cmd_wr) begin
                  seq_acc = 1'b1;
               end
            end
            SQ_WORD: begin
               if (arr_wr || stat_wr) begin
                  seq_acc = 1'b1;
               end else if (cmd_wr) begin
                  if (!op_legal(cmd_code)) seq_acc = 1'b1;
                  else if (cmd_code == OP_ABORT) begin
                     seq_acc     = 1'b1;
                     kill_serase = 1'b1;
                  end else if (op_alters(cmd_code) && hit_q) begin
                     seq_prot = 1'b1;
                  end else begin
                     take_cmd = 1'b1;
                     nxt      = SQ_CMD;
                  end
               end
            end
            SQ_CMD: begin
               if (stat_wr) begin
                  if (stat_wdata[SB_EMPTY]) begin
                     launch = 1'b1;
                     nxt    = SQ_IDLE;
                  end else begin
                     seq_acc = 1'b1;
                  end
               end else if (arr_wr || cmd_wr) begin
                  seq_acc = 1'b1;
               end
            end
            default: nxt = SQ_IDLE;
         endcase
      end
   end

   assign acc_set  = seq_acc | (stop_req & ~done_flag) | fault_evt;
   assign prot_set = seq_prot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         prot_q <= 1'b0;
         acc_q  <= 1'b0;
         fail_q <= 1'b0;
         cmd_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
         hit_q  <= 1'b0;
      end else begin
         st <= (acc_set || prot_set) ? SQ_IDLE : nxt;
         if (acc_set) acc_q <= 1'b1;
         else if (stat_wr && stat_wdata[SB_ACC]) acc_q <= 1'b0;
         if (prot_set) prot_q <= 1'b1;
         else if (stat_wr && stat_wdata[SB_PROT]) prot_q <= 1'b0;
         if (stat_wr && special_mode) fail_q <= stat_wdata[SB_FAIL];
         if (take_word) begin
            addr_q <= arr_addr;
            data_q <= arr_data;
            hit_q  <= prot_hit;
         end
         if (take_cmd) cmd_q <= cmd_code;
      end
   end

   assign l_cmd  = cmd_q;
   assign l_addr = addr_q;
   assign l_data = data_q;

   // R2: a zero in an error bit leaves that error set
   p_w0_keeps_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !stat_wdata[SB_ACC] && acc_q) |=> acc_q);

   // R4: zero to the empty bit inside a sequence raises an access error
   p_abort_w0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != SQ_IDLE) && stat_wr && !stat_wdata[SB_EMPTY]) |=> acc_q);

   // R11: stop while a command is pending raises an access error
   p_stop_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !done_flag) |=> acc_q);

   // R12: fail bit changes only in special mode
   p_fail_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode) |=> $stable(fail_q));

endmodule

// File: rtl/fcc_pipe.sv
module fcc_pipe
   import fcc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [CMD_W-1:0]  l_cmd,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_data,
   input  logic [CNT_W-1:0]  lat,
   input  logic              hold,
   input  logic              fault,
   input  logic              kill_serase,
   output logic              buf_valid,
   output logic              act_valid,
   output logic              fault_evt,
   output logic              start_q,
   output logic [CMD_W-1:0]  x_cmd,
   output logic [ADDR_W-1:0] x_addr,
   output logic [DATA_W-1:0] x_data
);

   logic [CMD_W-1:0]  b_cmd,  a_cmd;
   logic [ADDR_W-1:0] b_addr, a_addr;
   logic [DATA_W-1:0] b_data, a_data;
   logic [CNT_W-1:0]  cnt;
   logic              act_end, kill_now, slot_free, move;

   if (CNT_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("fcc_pipe: CNT_W and DATA_W must be positive");
   end

   assign act_end   = act_valid && (cnt == '0);
   assign fault_evt = fault && act_valid;
   assign kill_now  = kill_serase && act_valid && (a_cmd == OP_SERASE);
   assign slot_free = !act_valid || act_end;
   assign move      = buf_valid && slot_free && !hold && !fault_evt && !kill_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_valid <= 1'b0;
         act_valid <= 1'b0;
         start_q   <= 1'b0;
         cnt       <= '0;
         b_cmd     <= '0;
         b_addr    <= '0;
         b_data    <= '0;
         a_cmd     <= '0;
         a_addr    <= '0;
         a_data    <= '0;
      end else begin
         start_q <= move;
         if (fault_evt) begin
            act_valid <= 1'b0;
            buf_valid <= 1'b0;
         end else begin
            if (move) begin
               act_valid <= 1'b1;
               a_cmd     <= b_cmd;
               a_addr    <= b_addr;
               a_data    <= b_data;
               cnt       <= lat;
               buf_valid <= 1'b0;
            end else if (act_end || kill_now) begin
               act_valid <= 1'b0;
            end else if (act_valid) begin
               cnt <= cnt - 1'b1;
            end
            if (launch) begin
               buf_valid <= 1'b1;
               b_cmd     <= l_cmd;
               b_addr    <= l_addr;
               b_data    <= l_data;
            end
         end
      end
   end

   assign x_cmd  = a_cmd;
   assign x_addr = a_addr;
   assign x_data = a_data;

   // R3: an accepted launch occupies the buffer next cycle
   p_launch_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !fault_evt) |=> buf_valid);

   // R10: a fault empties both slots
   p_fault_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && act_valid) |=> (!act_valid && !buf_valid));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 8,
   parameter int WORD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              arr_wr,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              prot_hit,
   input  logic              cmd_wr,
   input  logic [7:0]        cmd_code,
   input  logic              stat_wr,
   input  logic [3:0]        stat_wdata,
   input  logic              ie_wr,
   input  logic [1:0]        ie_wdata,
   input  logic              stop_req,
   input  logic [CNT_W-1:0]  exec_lat,
   input  logic              exec_fault,
   output logic              flag_empty,
   output logic              flag_done,
   output logic              flag_prot,
   output logic              flag_acc,
   output logic              flag_fail,
   output logic              irq_empty,
   output logic              irq_done,
   output logic              exec_start,
   output logic              exec_busy,
   output logic [7:0]        exec_cmd,
   output logic [ADDR_W-1:0] exec_addr,
   output logic [DATA_W-1:0] exec_data
);

   logic              launch, kill_serase, fault_evt;
   logic              buf_valid, act_valid;
   logic [CMD_W-1:0]  l_cmd;
   logic [ADDR_W-1:0] l_addr;
   logic [DATA_W-1:0] l_data;
   logic [1:0]        ie_q;

   assign flag_empty = ~buf_valid;
   assign flag_done  = ~buf_valid & ~act_valid;
   assign exec_busy  = act_valid;

   fcc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .special_mode(special_mode),
      .arr_wr      (arr_wr),
      .arr_addr    (arr_addr),
      .arr_data    (arr_data),
      .prot_hit    (prot_hit),
      .cmd_wr      (cmd_wr),
      .cmd_code    (cmd_code),
      .stat_wr     (stat_wr),
      .stat_wdata  (stat_wdata),
      .stop_req    (stop_req),
      .fault_evt   (fault_evt),
      .done_flag   (flag_done),
      .buf_free    (flag_empty),
      .launch      (launch),
      .kill_serase (kill_serase),
      .l_cmd       (l_cmd),
      .l_addr      (l_addr),
      .l_data      (l_data),
      .prot_q      (flag_prot),
      .acc_q       (flag_acc),
      .fail_q      (flag_fail)
   );

   fcc_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .l_cmd      (l_cmd),
      .l_addr     (l_addr),
      .l_data     (l_data),
      .lat        (exec_lat),
      .hold       (flag_prot | flag_acc),
      .fault      (exec_fault),
      .kill_serase(kill_serase),
      .buf_valid  (buf_valid),
      .act_valid  (act_valid),
      .fault_evt  (fault_evt),
      .start_q    (exec_start),
      .x_cmd      (exec_cmd),
      .x_addr     (exec_addr),
      .x_data     (exec_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ie_q <= 2'b00;
      else if (ie_wr) ie_q <= ie_wdata;
   end

   assign irq_empty = flag_empty & ie_q[0];
   assign irq_done  = flag_done & ie_q[1];

   // R5: completion implies an empty buffer
   p_done_needs_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_done |-> flag_empty);

   // R5: a command entering execution keeps completion low
   p_start_done_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_start |-> !flag_done);

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        special_mode = 1'b0;
   logic        arr_wr = 1'b0;
   logic [15:0] arr_addr = '0;
   logic [15:0] arr_data = '0;
   logic        prot_hit = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic        stat_wr = 1'b0;
   logic [3:0]  stat_wdata = '0;
   logic        ie_wr = 1'b0;
   logic [1:0]  ie_wdata = '0;
   logic        stop_req = 1'b0;
   logic [7:0]  exec_lat = 8'd3;
   logic        exec_fault = 1'b0;
   logic        flag_empty, flag_done, flag_prot, flag_acc, flag_fail;
   logic        irq_empty, irq_done, exec_start, exec_busy;
   logic [7:0]  exec_cmd;
   logic [15:0] exec_addr, exec_data;

   int n_chk = 0;
   int n_bad = 0;
   int n_starts = 0;
   logic [7:0]  last_cmd = '0;
   logic [15:0] last_addr = '0;
   logic [15:0] last_data = '0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   flash_cmd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_data(arr_data), .prot_hit(prot_hit),
      .cmd_wr(cmd_wr), .cmd_code(cmd_code), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .ie_wr(ie_wr), .ie_wdata(ie_wdata), .stop_req(stop_req), .exec_lat(exec_lat),
      .exec_fault(exec_fault), .flag_empty(flag_empty), .flag_done(flag_done),
      .flag_prot(flag_prot), .flag_acc(flag_acc), .flag_fail(flag_fail),
      .irq_empty(irq_empty), .irq_done(irq_done), .exec_start(exec_start),
      .exec_busy(exec_busy), .exec_cmd(exec_cmd), .exec_addr(exec_addr), .exec_data(exec_data)
   );

   // start monitor, sampled 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && exec_start) begin
         n_starts++;
         last_cmd  = exec_cmd;
         last_addr = exec_addr;
         last_data = exec_data;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic p_word(input logic [15:0] a, input logic [15:0] d, input logic hit);
      @(negedge clk);
      arr_wr = 1'b1; arr_addr = a; arr_data = d; prot_hit = hit;
      @(negedge clk);
      arr_wr = 1'b0; prot_hit = 1'b0;
   endtask

   task automatic p_cmd(input logic [7:0] c);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_code = c;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic p_stat(input logic [3:0] v);
      @(negedge clk);
      stat_wr = 1'b1; stat_wdata = v;
      @(negedge clk);
      stat_wr = 1'b0;
   endtask

   task automatic full_seq(input logic [15:0] a, input logic [15:0] d, input logic [7:0] c);
      p_word(a, d, 1'b0);
      p_cmd(c);
      p_stat(4'b0001);
   endtask

   task automatic clr_errs();
      p_stat(4'b0110);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 400 && !flag_done; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 empty", flag_empty, 1);
      chk("R1 done", flag_done, 1);
      chk("R1 prot", flag_prot, 0);
      chk("R1 acc", flag_acc, 0);
      chk("R1 fail", flag_fail, 0);
      chk("R1 irqs", {irq_empty, irq_done}, 0);
      chk("R1 busy", exec_busy, 0);
   endtask

   task automatic t_basic();
      int s0 = n_starts;
      exec_lat = 8'd3;
      full_seq(16'h0100, 16'hBEEF, 8'h22);
      chk("R3 buffer occupied", flag_empty, 0);
      chk("R5 done low with buffer", flag_done, 0);
      @(negedge clk);
      chk("R3 start pulse", exec_start, 1);
      chk("R3 exec cmd", exec_cmd, 8'h22);
      chk("R3 exec addr", exec_addr, 16'h0100);
      chk("R3 exec data", exec_data, 16'hBEEF);
      chk("R3 empty again", flag_empty, 1);
      chk("R5 done low while busy", flag_done, 0);
      wait_done();
      chk("R5 done after finish", flag_done, 1);
      chk("R3 one start", n_starts - s0, 1);
      chk("R3 no error", flag_acc, 0);
   endtask

   task automatic t_abort_w0();
      int s0 = n_starts;
      p_word(16'h0200, 16'h1234, 1'b0);
      p_stat(4'b0000);
      chk("R4 abort after word", flag_acc, 1);
      clr_errs();
      chk("R2 acc cleared", flag_acc, 0);
      p_stat(4'b0000);
      chk("R4 zero outside sequence", flag_acc, 0);
      p_word(16'h0200, 16'h1234, 1'b0);
      p_cmd(8'h22);
      p_stat(4'b0000);
      chk("R4 abort after code", flag_acc, 1);
      idle(4);
      chk("R4 aborted nothing started", n_starts - s0, 0);
      clr_errs();
   endtask

   task automatic t_w1c();
      p_cmd(8'h22);
      chk("R7 code without word", flag_acc, 1);
      p_stat(4'b0010);
      chk("R2 zero keeps acc", flag_acc, 1);
      p_stat(4'b0100);
      chk("R2 one clears acc", flag_acc, 0);
      p_word(16'h0300, 16'h0, 1'b1);
      p_cmd(8'h33);
      chk("R9 protected erase", flag_prot, 1);
      chk("R9 no acc", flag_acc, 0);
      p_stat(4'b0100);
      chk("R2 zero keeps prot", flag_prot, 1);
      p_stat(4'b0010);
      chk("R2 one clears prot", flag_prot, 0);
   endtask

   task automatic t_order();
      int s0;
      p_word(16'h0400, 16'h0, 1'b0);
      p_word(16'h0402, 16'h0, 1'b0);
      chk("R7 second word", flag_acc, 1);
      clr_errs();
      p_word(16'h0400, 16'h0, 1'b0);
      p_stat(4'b0001);
      chk("R7 launch before code", flag_acc, 1);
      clr_errs();
      p_word(16'h0401, 16'h0, 1'b0);
      chk("R7 misaligned word", flag_acc, 1);
      clr_errs();
      // buffer occupied behind a long command
      s0 = n_starts;
      exec_lat = 8'd20;
      full_seq(16'h0500, 16'hAAAA, 8'h22);
      full_seq(16'h0600, 16'hBBBB, 8'h44);
      chk("R5 done low with both slots", flag_done, 0);
      p_word(16'h0700, 16'h0, 1'b0);
      chk("R7 word while buffer full", flag_acc, 1);
      idle(30);
      chk("R6 buffered held", n_starts - s0, 1);
      chk("R6 buffer still full", flag_empty, 0);
      chk("R6 slot idle", exec_busy, 0);
      exec_lat = 8'd2;
      clr_errs();
      wait_done();
      chk("R6 released after clear", n_starts - s0, 2);
      chk("R6 released code", last_cmd, 8'h44);
   endtask

   task automatic t_codes();
      p_word(16'h0800, 16'h0, 1'b0);
      p_cmd(8'h99);
      chk("R8 illegal code", flag_acc, 1);
      clr_errs();
      exec_lat = 8'd40;
      full_seq(16'h0900, 16'h0, 8'h33);
      idle(1);
      chk("R8 erase running", exec_busy, 1);
      p_word(16'h0902, 16'h0, 1'b0);
      p_cmd(8'h55);
      chk("R8 abort sets acc", flag_acc, 1);
      chk("R8 erase ended", exec_busy, 0);
      chk("R8 done after abort", flag_done, 1);
      clr_errs();
   endtask

   task automatic t_protect();
      int s0 = n_starts;
      p_word(16'h0A00, 16'h5555, 1'b1);
      p_cmd(8'h22);
      chk("R9 protected program", flag_prot, 1);
      // R6: steps ignored while an error is set
      exec_lat = 8'd2;
      full_seq(16'h0A10, 16'h1, 8'h22);
      idle(4);
      chk("R6 no start under error", n_starts - s0, 0);
      chk("R6 steps ignored no acc", flag_acc, 0);
      p_stat(4'b0010);
      p_word(16'h0A00, 16'h5555, 1'b1);
      p_cmd(8'h11);
      p_stat(4'b0001);
      wait_done();
      chk("R9 verify ignores protection", n_starts - s0, 1);
      chk("R9 verify code", last_cmd, 8'h11);
      chk("R9 no prot on verify", flag_prot, 0);
   endtask

   task automatic t_pipe();
      int s0 = n_starts;
      int viol = 0;
      int hand = 0;
      exec_lat = 8'd12;
      full_seq(16'h0B00, 16'h0101, 8'h33);
      full_seq(16'h0C00, 16'h0202, 8'h22);
      for (int i = 0; i < 200 && !flag_done; i++) begin
         @(negedge clk);
         if (flag_done && (exec_busy || !flag_empty)) viol++;
         if (exec_start) hand++;
      end
      chk("R5 done stayed low across hand-off", viol, 0);
      chk("R5 hand-off seen", hand, 1);
      chk("R5 done finally", flag_done, 1);
      chk("R3 two starts in order", n_starts - s0, 2);
      chk("R3 second addr", last_addr, 16'h0C00);
      chk("R3 second data", last_data, 16'h0202);
   endtask

   task automatic t_fault();
      int s0 = n_starts;
      exec_lat = 8'd25;
      full_seq(16'h0D00, 16'h0, 8'h22);
      full_seq(16'h0E00, 16'h0, 8'h22);
      @(negedge clk);
      exec_fault = 1'b1;
      @(negedge clk);
      exec_fault = 1'b0;
      chk("R10 fault acc", flag_acc, 1);
      chk("R10 active ended", exec_busy, 0);
      chk("R10 buffer discarded", flag_empty, 1);
      chk("R10 done", flag_done, 1);
      clr_errs();
      idle(5);
      chk("R10 buffered never started", n_starts - s0, 1);
   endtask

   task automatic t_stop();
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      chk("R11 stop when idle", flag_acc, 0);
      exec_lat = 8'd10;
      full_seq(16'h0F00, 16'h0, 8'h22);
      idle(2);
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      chk("R11 stop while busy", flag_acc, 1);
      wait_done();
      clr_errs();
   endtask

   task automatic t_fail();
      p_stat(4'b1000);
      chk("R12 fail locked outside test mode", flag_fail, 0);
      special_mode = 1'b1;
      p_stat(4'b1000);
      special_mode = 1'b0;
      chk("R12 fail written in test mode", flag_fail, 1);
      p_word(16'h1000, 16'h0, 1'b0);
      p_stat(4'b0000);
      chk("R12 word ignored while fail", flag_acc, 0);
      special_mode = 1'b1;
      p_stat(4'b0000);
      special_mode = 1'b0;
      chk("R12 fail cleared", flag_fail, 0);
   endtask

   task automatic t_irq();
      chk("R13 irqs off by default", {irq_empty, irq_done}, 0);
      @(negedge clk); ie_wr = 1'b1; ie_wdata = 2'b11;
      @(negedge clk); ie_wr = 1'b0;
      chk("R13 both irqs", {irq_empty, irq_done}, 2'b11);
      @(negedge clk); ie_wr = 1'b1; ie_wdata = 2'b01;
      @(negedge clk); ie_wr = 1'b0;
      chk("R13 done irq masked", {irq_empty, irq_done}, 2'b10);
      exec_lat = 8'd4;
      full_seq(16'h1100, 16'h0, 8'h22);
      chk("R13 empty irq low with buffer", irq_empty, 0);
      wait_done();
      @(negedge clk); ie_wr = 1'b1; ie_wdata = 2'b00;
      @(negedge clk); ie_wr = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_abort_w0();
      t_w1c();
      t_order();
      t_codes();
      t_protect();
      t_pipe();
      t_fault();
      t_stop();
      t_fail();
      t_irq();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL all requirements: watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule